// File: doc/BRIEF.md
# Glitch-Free Reference Clock Switch

This block picks one of two unrelated clocks and drives it onto a clock output without ever letting a shortened pulse through. The first source is a raw reference clock that a programmable prescaler divides by M. The second is an external clock that arrives as it is. An active-low select input asks for the external source. That input is obeyed only while a power-down control bit is clear. When the bit is set, the internal source is used.

Each source has its own enable. The enable is resynchronised on that source's falling edges, so a source can only be switched in or out while it is low. On a switch, the old source is shut off first. The new source is admitted only after that, through its own two-flop synchronizer, so the output sits low between the last old pulse and the first new one. A second output carries the switched clock divided by a programmable N. It inherits the same clean behaviour.

Top module: `clksw_top`

## Requirements
- R1: The internal clock is the raw reference divided by `m_div`. For `m_div` of 2 or more, each internal period spans `m_div` raw periods and is high for the first ceil(`m_div`/2) of them. A value of 0 or 1 passes the raw reference through unchanged.
- R2: The external source is requested when `sel_n` is 0 and `pdn` is 0. Every other combination requests the internal source. Once reset is released, the requested source drives `out0` at its own frequency.
- R3: Every high pulse on `out0` is one complete high phase of the source that is enabled. Each source enable changes only while that source's clock is low.
- R4: On a switch, the old source is disabled before the new one can be enabled. `out0` then stays low for at least one full period of the new source before the new source's first rising edge.
- R5: The first rising edge from the new source comes no later than two periods of the old source plus three periods of the new source after the request changes.
- R6: While `pdn` is 1, changes on `sel_n` have no effect, and the internal source stays on `out0`.
- R7: A switch from the external back to the internal source follows the same disable-then-enable order and the same bounds as the opposite direction.
- R8: `out_div` is `out0` divided by `n_div`. It is high for ceil(`n_div`/2) of every `n_div` `out0` periods. A value of 0 or 1 makes `out_div` equal to `out0`.
- R9: While `rst` is 1, both outputs are low and both enables and both divider counters are cleared. After release, the internal source is taken first when it is requested.
- R10: At no time are both source enables set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_raw | input | 1 | Raw internal reference clock, before the prescaler |
| clk_ext | input | 1 | External clock, unrelated to `clk_raw` |
| rst | input | 1 | Active-high reset, synchronous to `clk_raw` in the prescaler |
| sel_n | input | 1 | Source select: 0 requests external, 1 requests internal |
| pdn | input | 1 | Power-down control bit; when 1, forces the internal source |
| m_div | input | M_W | Prescaler ratio for the internal source |
| n_div | input | N_W | Output divider ratio for `out_div` |
| out0 | output | 1 | Switched clock at the selected source frequency |
| out_div | output | 1 | Switched clock divided by `n_div` |

## Verification
The assertions rely on three things about the inputs. First, `sel_n` and `pdn` are held steady long enough for a hand-over to finish, which means several falling edges of both clocks. Second, both clocks keep running. Third, `m_div` and `n_div` change only while `rst` is high. The bench follows these rules. It changes the request only after the previous hand-over has been seen completing on `out0`. It rewrites the ratios only inside a reset window. It drives inputs a moment after a raw-clock falling edge. The pulse monitor measures every `out0` high pulse and accepts only the exact high width of one of the two sources.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned IDX_INT = 0;
  localparam int unsigned IDX_EXT = 1;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clksw_src_e;
endpackage

// File: rtl/clksw_divider.sv
`timescale 1ns/1ps
// Ratio divider shared by the prescaler and the output divider.
// ASYNC_RST picks the reset style: the output divider is clocked by the
// switched clock, which is held low during reset, so it needs async clear.
module clksw_divider #(
  parameter int unsigned W         = 8,
  parameter bit          ASYNC_RST = 1'b0
) (
  input  logic         clk_in,
  input  logic         rst,
  input  logic [W-1:0] ratio,
  output logic         clk_out
);
  localparam int unsigned CW = W + 1;

  logic [W-1:0]  r_eff;
  logic [CW-1:0] hi_cnt;
  logic [W-1:0]  cnt_q;
  logic [W-1:0]  cnt_nxt;
  logic          div_q;
  logic          bypass;

  always_comb begin
    r_eff   = (ratio == '0) ? W'(1) : ratio;
    hi_cnt  = (CW'(r_eff) + CW'(1)) >> 1;
    bypass  = (r_eff == W'(1));
    cnt_nxt = (cnt_q >= r_eff - W'(1)) ? '0 : cnt_q + W'(1);
  end

  if (ASYNC_RST) begin : g_arst
    always_ff @(posedge clk_in or posedge rst) begin
      if (rst) begin
        cnt_q <= '0;
        div_q <= 1'b0;
      end else begin
        cnt_q <= cnt_nxt;
        div_q <= (CW'(cnt_nxt) < hi_cnt);
      end
    end
  end else begin : g_srst
    always_ff @(posedge clk_in) begin
      if (rst) begin
        cnt_q <= '0;
        div_q <= 1'b0;
      end else begin
        cnt_q <= cnt_nxt;
        div_q <= (CW'(cnt_nxt) < hi_cnt);
      end
    end
  end

  assign clk_out = bypass ? clk_in : div_q;

  // R1 / R8: the phase counter never leaves its ratio window
  a_r1_r8_count_range: assert property (@(posedge clk_in) disable iff (rst)
    cnt_q < r_eff)
    else $error("divider count out of range");
endmodule

// File: rtl/clksw_en_sync.sv
`timescale 1ns/1ps
// Two-flop enable synchronizer on the falling edge of its own source.
module clksw_en_sync (
  input  logic src_clk,
  input  logic rst,
  input  logic want,
  input  logic other_en,
  output logic en_q
);
  logic s1_q;

  always_ff @(negedge src_clk or posedge rst) begin
    if (rst) begin
      s1_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      s1_q <= want & ~other_en;
      en_q <= s1_q;
    end
  end

  // R3: the enable moves only while its source is low
  always @(en_q) begin
    if (!rst) begin
      a_r3_en_moves_low: assert (!src_clk)
        else $error("enable changed while source high");
    end
  end

  // R4: a freshly raised enable found the other source already off
  a_r4_other_off_first: assert property (@(negedge src_clk) disable iff (rst)
    $rose(en_q) |-> !other_en)
    else $error("enable rose while other source enabled");
endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top
  import clksw_pkg::*;
#(
  parameter int unsigned M_W = 8,
  parameter int unsigned N_W = 8
) (
  input  logic           clk_raw,
  input  logic           clk_ext,
  input  logic           rst,
  input  logic           sel_n,
  input  logic           pdn,
  input  logic [M_W-1:0] m_div,
  input  logic [N_W-1:0] n_div,
  output logic           out0,
  output logic           out_div
);
  logic               clk_int;
  clksw_src_e         want_src;
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] want;
  logic [NUM_SRC-1:0] en;
  logic               gated;

  clksw_divider #(.W(M_W), .ASYNC_RST(1'b0)) u_prescale (
    .clk_in (clk_raw),
    .rst    (rst),
    .ratio  (m_div),
    .clk_out(clk_int)
  );

  always_comb begin
    want_src         = (!pdn && !sel_n) ? SRC_EXT : SRC_INT;
    src_clk[IDX_INT] = clk_int;
    src_clk[IDX_EXT] = clk_ext;
    want[IDX_INT]    = (want_src == SRC_INT);
    want[IDX_EXT]    = (want_src == SRC_EXT);
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    clksw_en_sync u_sync (
      .src_clk (src_clk[g]),
      .rst     (rst),
      .want    (want[g]),
      .other_en(en[NUM_SRC-1-g]),
      .en_q    (en[g])
    );
  end

  always_comb begin
    gated = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      gated = gated | (src_clk[i] & en[i]);
    end
    out0 = ~rst & gated;
  end

  clksw_divider #(.W(N_W), .ASYNC_RST(1'b1)) u_outdiv (
    .clk_in (out0),
    .rst    (rst),
    .ratio  (n_div),
    .clk_out(out_div)
  );

  // R10: never two enables at once, seen from either clock
  a_r10_single_src_ext: assert property (@(negedge clk_ext) disable iff (rst)
    $countones(en) <= 1)
    else $error("both sources enabled");
  a_r10_single_src_raw: assert property (@(posedge clk_raw) disable iff (rst)
    $countones(en) <= 1)
    else $error("both sources enabled");

  // R9: outputs quiet while reset is held
  always @(posedge clk_raw) begin
    if (rst) begin
      a_r9_reset_quiet: assert (!out0 && !out_div && en == '0)
        else $error("activity during reset");
    end
  end
endmodule

// File: tb/clksw_top_tb_top.sv
`timescale 1ns/1ps
module clksw_top_tb_top;
  localparam int RAW_PERIOD = 10;
  localparam int M_W = 8;
  localparam int N_W = 8;

  logic           clk_raw = 1'b0;
  logic           clk_ext = 1'b0;
  logic           rst     = 1'b1;
  logic           sel_n   = 1'b1;
  logic           pdn     = 1'b0;
  logic [M_W-1:0] m_div   = 8'd3;
  logic [N_W-1:0] n_div   = 8'd4;
  logic           out0;
  logic           out_div;

  int ext_half  = 7;
  int errors    = 0;
  int checks    = 0;
  int int_hi    = 20;
  int ext_hi    = 7;
  bit mon_en    = 1'b0;
  int rise_t    = 0;
  int last_fall = 0;

  clksw_top #(.M_W(M_W), .N_W(N_W)) dut_i (
    .clk_raw(clk_raw),
    .clk_ext(clk_ext),
    .rst    (rst),
    .sel_n  (sel_n),
    .pdn    (pdn),
    .m_div  (m_div),
    .n_div  (n_div),
    .out0   (out0),
    .out_div(out_div)
  );

  always #(RAW_PERIOD/2) clk_raw = ~clk_raw;
  initial begin
    #3;
    forever #(ext_half) clk_ext = ~clk_ext;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hi_of_int(input int m);
    if (m <= 1) return RAW_PERIOD / 2;
    return ((m + 1) / 2) * RAW_PERIOD;
  endfunction

  // Reference model of legal pulses: each high pulse on out0 must be a
  // whole high phase of one of the two sources (R3).
  always @(posedge out0) rise_t = int'($time);
  always @(negedge out0) begin
    if (mon_en && !rst) begin
      check(((int'($time) - rise_t) == int_hi) || ((int'($time) - rise_t) == ext_hi),
            "R3 whole pulse", int'($time) - rise_t, int_hi);
    end
    last_fall = int'($time);
  end

  task automatic do_reset(input int m, input int n);
    mon_en = 1'b0;
    @(negedge clk_raw);
    rst   = 1'b1;
    m_div = M_W'(m);
    n_div = N_W'(n);
    int_hi = hi_of_int(m);
    repeat (5) @(negedge clk_raw);
    check(out0 == 1'b0, "R9 out0 low in reset", int'(out0), 0);
    check(out_div == 1'b0, "R9 out_div low in reset", int'(out_div), 0);
    rst = 1'b0;
    mon_en = 1'b1;
  endtask

  task automatic meas0(output int hi, output int per);
    int t0, t1, t2;
    repeat (2) @(posedge out0);
    t0 = int'($time);
    @(negedge out0); t1 = int'($time);
    @(posedge out0); t2 = int'($time);
    hi = t1 - t0;
    per = t2 - t0;
  endtask

  task automatic measd(output int hi, output int per);
    int t0, t1, t2;
    repeat (2) @(posedge out_div);
    t0 = int'($time);
    @(negedge out_div); t1 = int'($time);
    @(posedge out_div); t2 = int'($time);
    hi = t1 - t0;
    per = t2 - t0;
  endtask

  task automatic handover(input int new_hi, input int new_per, input int old_per,
                          input string tag);
    int ts, tr, gap, hi;
    bit found;
    ts = int'($time);
    found = 1'b0;
    tr = ts;
    gap = 0;
    for (int k = 0; k < 40 && !found; k++) begin
      @(posedge out0);
      tr = int'($time);
      gap = tr - last_fall;
      @(negedge out0);
      hi = int'($time) - tr;
      if (hi == new_hi) found = 1'b1;
    end
    check(found, {tag, " new source reached out0"}, int'(found), 1);
    check(gap >= new_per, {tag, " R4 low gap"}, gap, new_per);
    check((tr - ts) <= 2 * old_per + 3 * new_per, {tag, " R5 latency"},
          tr - ts, 2 * old_per + 3 * new_per);
  endtask

  initial begin
    int h, p;
    // R9 / R1 / R8: internal after reset, M=3, N=4
    do_reset(3, 4);
    meas0(h, p);
    check(h == 20, "R1 internal high", h, 20);
    check(p == 30, "R2 internal period", p, 30);
    measd(h, p);
    check(h == 60, "R8 div high", h, 60);
    check(p == 120, "R8 div period", p, 120);

    // R2: request external
    @(negedge clk_raw); #1 sel_n = 1'b0;
    handover(7, 14, 30, "R2 int->ext");
    meas0(h, p);
    check(h == 7, "R2 external high", h, 7);
    check(p == 14, "R2 external period", p, 14);
    measd(h, p);
    check(p == 56, "R8 div of external", p, 56);

    // R6: power-down bit forces internal
    @(negedge clk_raw); #1 pdn = 1'b1;
    handover(20, 30, 14, "R6 pdn forces int");
    for (int k = 0; k < 3; k++) begin
      #37 sel_n = ~sel_n;
    end
    #200;
    meas0(h, p);
    check(h == 20, "R6 select ignored high", h, 20);
    check(p == 30, "R6 select ignored period", p, 30);
    @(negedge clk_raw); #1 sel_n = 1'b0;
    #150;
    meas0(h, p);
    check(h == 20, "R6 select low ignored", h, 20);

    // R7: back and forth once pdn clears
    @(negedge clk_raw); #1 pdn = 1'b0;
    handover(7, 14, 30, "R2 pdn clear");
    @(negedge clk_raw); #1 sel_n = 1'b1;
    handover(20, 30, 14, "R7 ext->int");

    // R1 bypass, R8 odd N
    do_reset(1, 3);
    meas0(h, p);
    check(h == 5, "R1 bypass high", h, 5);
    check(p == 10, "R1 bypass period", p, 10);
    measd(h, p);
    check(h == 20, "R8 odd high", h, 20);
    check(p == 30, "R8 odd period", p, 30);
    @(negedge clk_raw); #1 sel_n = 1'b0;
    handover(7, 14, 10, "R2 fast int->ext");
    measd(h, p);
    check(p == 42, "R8 odd of external", p, 42);
    @(negedge clk_raw); #1 sel_n = 1'b1;
    handover(5, 10, 14, "R7 ext->fast int");

    // New external frequency while internal runs, then M=2, N=1
    ext_half = 4;
    ext_hi = 4;
    #100;
    do_reset(2, 1);
    meas0(h, p);
    check(h == 10, "R1 even high", h, 10);
    check(p == 20, "R1 even period", p, 20);
    measd(h, p);
    check(h == 10 && p == 20, "R8 ratio one", p, 20);
    @(negedge clk_raw); #1 sel_n = 1'b0;
    handover(4, 8, 20, "R2 int->ext fast");
    meas0(h, p);
    check(p == 8, "R2 new external period", p, 8);

    // R9: reset while external is on the output
    do_reset(2, 1);
    #200;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(RAW_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule